// File: doc/BRIEF.md
# Multi-format audio serial transmitter

The block turns left/right PCM sample pairs into a serial data stream. The bit clock and frame clock come from outside; neither is generated here. Both are oversampled in the block's own clock domain. A new data bit is launched on each falling edge of the normalized bit clock, so a receiver can sample it on the next rising edge. The frame clock is read at the same launch point. A format selector chooses where the sample bits sit relative to the frame clock:

- I2S
- left-justified
- right-justified
- two DSP pulse modes

Two separate controls invert the bit clock and the frame clock.

At each frame start the block offers `ready_o` for a single clock and takes a sample pair if `valid_i` is high in that cycle. If no pair is offered, the frame is sent as zeros and a sticky underrun flag is raised. Format and sample width are captured at frame starts only. A change made in the middle of a frame therefore never corrupts the frame already on the wire.

Top module: `aud_ser_tx`

## Requirements
- R1: Left-justified (fmt_i=1): the channel MSB is launched in the same slot as the frame-clock transition. Frame low carries the left channel (left_i) and frame high carries the right channel (right_i). Sample bits are taken from the low W bits of the input word.
- R2: I2S (fmt_i=0): the output equals the left-justified stream delayed by exactly one bit slot, so the MSB follows the frame transition by one bit.
- R3: Right-justified (fmt_i=2): the channel LSB sits in the last slot before the next frame transition. The MSB starts W slots before that transition. The half-frame length is measured from the previous half-frame.
- R4: DSP B (fmt_i=4): the left MSB is launched in the slot where the frame pulse rises. The W right-channel bits follow immediately after the W left bits.
- R5: DSP A (fmt_i=3): the output equals the DSP B stream delayed by one bit slot.
- R6: With bclk_inv_i=1, data launches on the physical rising edge of bclk_i instead of the falling edge, and sdata_o changes only after a launch edge.
- R7: With frame_inv_i=1, the frame clock is inverted before channel selection and before frame-start detection.
- R8: wsel_i selects the sample width W: 0 gives 16, 1 gives 20, 2 gives 24 and 3 gives 32 bits. Every slot of a half-frame (or of a DSP frame) outside the sample bits carries zero.
- R9: ready_o is high for exactly one clock per frame, at the frame-start launch. A frame start is the falling edge of the normalized frame clock in I2S and justified modes, and its rising edge in DSP modes. A pair is taken when valid_i is high in that cycle.
- R10: If valid_i is low at a frame start, the whole frame is sent as zeros and underrun_o is set and stays set. A one on underrun_clr_i clears it, and a new underrun in the same cycle wins over the clear.
- R11: A change of fmt_i or wsel_i takes effect only at the next frame start.
- R12: After reset, sdata_o, underrun_o and ready_o are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Oversampling clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| bclk_i | input | 1 | External bit clock |
| frame_i | input | 1 | External frame / LR clock |
| fmt_i | input | 3 | Framing mode: 0 I2S, 1 left-justified, 2 right-justified, 3 DSP A, 4 DSP B |
| wsel_i | input | 2 | Sample width select: 16/20/24/32 bits |
| bclk_inv_i | input | 1 | Invert bit clock polarity |
| frame_inv_i | input | 1 | Invert frame clock polarity |
| left_i | input | SAMPLE_W | Left sample, LSB aligned |
| right_i | input | SAMPLE_W | Right sample, LSB aligned |
| valid_i | input | 1 | Sample pair offered |
| ready_o | output | 1 | Pair accepted this cycle if valid_i |
| underrun_clr_i | input | 1 | Clear the underrun flag |
| sdata_o | output | 1 | Serial data |
| underrun_o | output | 1 | Sticky underrun flag |

## Verification
The bench aims at the tight case where the sample width equals the half-frame length, with 32 bits in 32 slots.

- In this case the I2S LSB of the right channel must spill into the first slot of the next frame. A design that zero-fills that slot, or inserts its delay only inside a channel, loses that bit.
- Right-justified frames are run at half-frame lengths of both 32 and 36 slots. A design that counts from the frame edge instead of the measured length puts the bits in the wrong slots.
- Width and format are changed in the middle of a frame to catch a design that applies them immediately.
- Both clock inversions are run, so that a launch on the wrong edge shows up as shifted data.
- An unfed frame checks that the flag is sticky, that the frame is all zeros, and that the design does not resend stale data.

// File: rtl/aud_ser_pkg.sv
package aud_ser_pkg;

  typedef enum logic [2:0] {
    FMT_I2S   = 3'd0,
    FMT_LJ    = 3'd1,
    FMT_RJ    = 3'd2,
    FMT_DSP_A = 3'd3,
    FMT_DSP_B = 3'd4
  } fmt_e;

  localparam int unsigned WBITS_W = 6;

  function automatic logic [WBITS_W-1:0] wsel_bits(input logic [1:0] sel);
    case (sel)
      2'd0:    return 6'd16;
      2'd1:    return 6'd20;
      2'd2:    return 6'd24;
      default: return 6'd32;
    endcase
  endfunction

  function automatic logic fmt_is_dsp(input fmt_e f);
    return (f == FMT_DSP_A) || (f == FMT_DSP_B);
  endfunction

  // formats whose stream is the base stream shifted by one slot
  function automatic logic fmt_is_late(input fmt_e f);
    return (f == FMT_I2S) || (f == FMT_DSP_A);
  endfunction

endpackage

// File: rtl/aud_ser_sync.sv
module aud_ser_sync (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic bclk_i,
  input  logic frame_i,
  input  logic bclk_inv_i,
  input  logic frame_inv_i,
  output logic launch_o,
  output logic ws_o
);
  logic b_q, f_q, bn_d_q, bn;

  assign bn       = b_q ^ bclk_inv_i;
  assign launch_o = bn_d_q & ~bn;
  assign ws_o     = f_q ^ frame_inv_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      b_q    <= 1'b0;
      f_q    <= 1'b0;
      bn_d_q <= 1'b0;
    end else begin
      b_q    <= bclk_i;
      f_q    <= frame_i;
      bn_d_q <= bn;
    end
  end
endmodule

// File: rtl/aud_ser_slot.sv
module aud_ser_slot #(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             launch_i,
  input  logic             trans_i,
  input  logic             rise_i,
  input  logic             dsp_i,
  output logic [CNT_W-1:0] pos_o,
  output logic [CNT_W-1:0] len_o
);
  logic [CNT_W-1:0] hc_q, dp_q, len_q, cur_hc, cur_dp;

  function automatic logic [CNT_W-1:0] sat_inc(input logic [CNT_W-1:0] x);
    return (x == '1) ? x : x + 1'b1;
  endfunction

  assign cur_hc = trans_i ? '0 : hc_q;
  assign cur_dp = rise_i  ? '0 : dp_q;
  assign pos_o  = dsp_i ? cur_dp : cur_hc;
  // slots in the half just closed
  assign len_o  = trans_i ? hc_q : len_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hc_q  <= '0;
      dp_q  <= '0;
      len_q <= '0;
    end else if (launch_i) begin
      hc_q <= sat_inc(cur_hc);
      dp_q <= sat_inc(cur_dp);
      if (trans_i) len_q <= hc_q;
    end
  end
endmodule

// File: rtl/aud_ser_pick.sv
module aud_ser_pick
  import aud_ser_pkg::*;
#(
  parameter int SAMPLE_W = 32,
  parameter int CNT_W    = 8
) (
  input  fmt_e                fmt_i,
  input  logic [WBITS_W-1:0]  wbits_i,
  input  logic                ch_i,
  input  logic [CNT_W-1:0]    pos_i,
  input  logic [CNT_W-1:0]    len_i,
  input  logic [SAMPLE_W-1:0] left_i,
  input  logic [SAMPLE_W-1:0] right_i,
  output logic                bit_o
);
  localparam int EW    = CNT_W + 1;
  localparam int IDX_W = $clog2(SAMPLE_W);

  logic [EW-1:0] p, w, l, w2, idx;
  logic          hit, use_r;
  logic [SAMPLE_W-1:0] word;

  assign p  = {1'b0, pos_i};
  assign l  = {1'b0, len_i};
  assign w  = EW'(wbits_i);
  assign w2 = w << 1;

  always_comb begin
    hit   = 1'b0;
    use_r = ch_i;
    idx   = '0;
    case (fmt_i)
      FMT_RJ: begin
        if ((p < l) && ((l - 1'b1 - p) < w)) begin
          hit = 1'b1;
          idx = l - 1'b1 - p;
        end
      end
      FMT_DSP_A, FMT_DSP_B: begin
        if (p < w) begin
          hit = 1'b1; use_r = 1'b0; idx = w - 1'b1 - p;
        end else if (p < w2) begin
          hit = 1'b1; use_r = 1'b1; idx = w2 - 1'b1 - p;
        end
      end
      default: begin
        if (p < w) begin
          hit = 1'b1;
          idx = w - 1'b1 - p;
        end
      end
    endcase
    word  = use_r ? right_i : left_i;
    bit_o = hit ? word[idx[IDX_W-1:0]] : 1'b0;
  end
endmodule

// File: rtl/aud_ser_tx.sv
module aud_ser_tx
  import aud_ser_pkg::*;
#(
  parameter int SAMPLE_W = 32,
  parameter int CNT_W    = 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                bclk_i,
  input  logic                frame_i,
  input  logic [2:0]          fmt_i,
  input  logic [1:0]          wsel_i,
  input  logic                bclk_inv_i,
  input  logic                frame_inv_i,
  input  logic [SAMPLE_W-1:0] left_i,
  input  logic [SAMPLE_W-1:0] right_i,
  input  logic                valid_i,
  output logic                ready_o,
  input  logic                underrun_clr_i,
  output logic                sdata_o,
  output logic                underrun_o
);
  logic launch, ws, prev_ws_q;
  logic trans, rise, fall, fs_evt, is_dsp_q;
  fmt_e fmt_q, fmt_eff;
  logic [1:0] wsel_q, wsel_eff;
  logic [SAMPLE_W-1:0] left_q, right_q, left_eff, right_eff;
  logic [CNT_W-1:0] pos, len;
  logic raw, d1_q, sdata_q, unr_q;

  aud_ser_sync u_sync (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .bclk_i     (bclk_i),
    .frame_i    (frame_i),
    .bclk_inv_i (bclk_inv_i),
    .frame_inv_i(frame_inv_i),
    .launch_o   (launch),
    .ws_o       (ws)
  );

  assign is_dsp_q = fmt_is_dsp(fmt_q);
  assign trans    = launch && (ws != prev_ws_q);
  assign rise     = trans && ws;
  assign fall     = trans && !ws;
  // frame start judged by the format in force
  assign fs_evt   = is_dsp_q ? rise : fall;
  assign ready_o  = fs_evt;

  // bypass so the first slot of a frame uses the newly taken settings
  assign fmt_eff   = fs_evt ? fmt_e'(fmt_i) : fmt_q;
  assign wsel_eff  = fs_evt ? wsel_i : wsel_q;
  assign left_eff  = fs_evt ? (valid_i ? left_i  : '0) : left_q;
  assign right_eff = fs_evt ? (valid_i ? right_i : '0) : right_q;

  aud_ser_slot #(.CNT_W(CNT_W)) u_slot (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .launch_i(launch),
    .trans_i (trans),
    .rise_i  (rise),
    .dsp_i   (is_dsp_q),
    .pos_o   (pos),
    .len_o   (len)
  );

  aud_ser_pick #(.SAMPLE_W(SAMPLE_W), .CNT_W(CNT_W)) u_pick (
    .fmt_i  (fmt_eff),
    .wbits_i(wsel_bits(wsel_eff)),
    .ch_i   (ws),
    .pos_i  (pos),
    .len_i  (len),
    .left_i (left_eff),
    .right_i(right_eff),
    .bit_o  (raw)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_ws_q <= 1'b0;
      fmt_q     <= FMT_I2S;
      wsel_q    <= 2'd3;
      left_q    <= '0;
      right_q   <= '0;
      d1_q      <= 1'b0;
      sdata_q   <= 1'b0;
    end else if (launch) begin
      prev_ws_q <= ws;
      d1_q      <= raw;
      sdata_q   <= fmt_is_late(fmt_eff) ? d1_q : raw;
      if (fs_evt) begin
        fmt_q   <= fmt_eff;
        wsel_q  <= wsel_eff;
        left_q  <= left_eff;
        right_q <= right_eff;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 unr_q <= 1'b0;
    else if (fs_evt && !valid_i) unr_q <= 1'b1;
    else if (underrun_clr_i)     unr_q <= 1'b0;
  end

  assign sdata_o    = sdata_q;
  assign underrun_o = unr_q;
endmodule

// File: rtl/aud_ser_tx_chk.sv
module aud_ser_tx_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic bclk_i,
  input logic bclk_inv_i,
  input logic valid_i,
  input logic ready_o,
  input logic underrun_clr_i,
  input logic underrun_o,
  input logic sdata_o
);
  logic c1_q, c2_q, ls_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      c1_q <= 1'b0;
      c2_q <= 1'b0;
      ls_q <= 1'b0;
    end else begin
      c1_q <= bclk_i;
      c2_q <= c1_q ^ bclk_inv_i;
      ls_q <= c2_q & ~(c1_q ^ bclk_inv_i);
    end
  end

  assert_ready_pulse_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |=> !ready_o);

  assert_underrun_set_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ready_o && !valid_i) |=> underrun_o);

  assert_underrun_sticky_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (underrun_o && !underrun_clr_i) |=> underrun_o);

  assert_underrun_clear_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (underrun_clr_i && !(ready_o && !valid_i)) |=> !underrun_o);

  assert_launch_edge_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(sdata_o) |-> ls_q);
endmodule

bind aud_ser_tx aud_ser_tx_chk chk_i (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .bclk_i        (bclk_i),
  .bclk_inv_i    (bclk_inv_i),
  .valid_i       (valid_i),
  .ready_o       (ready_o),
  .underrun_clr_i(underrun_clr_i),
  .underrun_o    (underrun_o),
  .sdata_o       (sdata_o)
);

// File: tb/aud_ser_tx_tb_top.sv
module aud_ser_tx_tb_top;
  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic bclk_i = 1'b0, frame_i = 1'b0;
  logic [2:0] fmt_i = 3'd0;
  logic [1:0] wsel_i = 2'd3;
  logic bclk_inv_i = 1'b0, frame_inv_i = 1'b0;
  logic [31:0] left_i = '0, right_i = '0;
  logic valid_i = 1'b0, underrun_clr_i = 1'b0;
  logic ready_o, sdata_o, underrun_o;

  int total = 0, bad = 0, rdy_cnt = 0, L = 32;
  bit done = 0;
  logic prev_raw = 1'b0;

  always #2.5 clk_i = ~clk_i;

  aud_ser_tx dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .bclk_i(bclk_i), .frame_i(frame_i),
    .fmt_i(fmt_i), .wsel_i(wsel_i), .bclk_inv_i(bclk_inv_i), .frame_inv_i(frame_inv_i),
    .left_i(left_i), .right_i(right_i), .valid_i(valid_i), .ready_o(ready_o),
    .underrun_clr_i(underrun_clr_i), .sdata_o(sdata_o), .underrun_o(underrun_o)
  );

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s act=%0h exp=%0h", tag, what, act, exp);
    end
  endtask

  function automatic int wbits(input logic [1:0] s);
    return (s == 0) ? 16 : (s == 1) ? 20 : (s == 2) ? 24 : 32;
  endfunction

  function automatic bit is_dsp(input logic [2:0] f);
    return (f == 3) || (f == 4);
  endfunction

  function automatic logic model_raw(input logic [2:0] f, input int w, input int len,
                                     input int s, input logic [31:0] l, input logic [31:0] r);
    int p;
    logic [31:0] wd;
    if (is_dsp(f)) begin
      if (s < w) return l[w-1-s];
      if (s < 2*w) return r[2*w-1-s];
      return 1'b0;
    end
    p  = (s >= len) ? s - len : s;
    wd = (s >= len) ? r : l;
    if (f == 2) return ((len-1-p) < w) ? wd[len-1-p] : 1'b0;
    return (p < w) ? wd[w-1-p] : 1'b0;
  endfunction

  function automatic string fmt_tag(input logic [2:0] f);
    case (f)
      3'd0: return "R2";
      3'd1: return "R1";
      3'd2: return "R3";
      3'd3: return "R5";
      default: return "R4";
    endcase
  endfunction

  task automatic wait_neg(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk_i);
      if (ready_o) rdy_cnt++;
    end
  endtask

  task automatic do_slot(input logic fr, output logic got);
    bclk_i  = bclk_inv_i;
    frame_i = fr ^ frame_inv_i;
    wait_neg(4);
    bclk_i = ~bclk_inv_i;
    wait_neg(2);
    got = sdata_o;
    wait_neg(2);
  endtask

  task automatic run_frame(input bit chk, input bit v, input logic [31:0] l,
                           input logic [31:0] r, input bit chg,
                           input logic [2:0] nf, input logic [1:0] nw, input string xtag);
    logic [2:0] mf;
    int w, miss, mslot;
    logic got, raw, exp, mg, me;
    string tag;
    mf = fmt_i; w = wbits(wsel_i);
    miss = 0; mslot = 0; mg = 0; me = 0;
    valid_i = v; left_i = l; right_i = r; rdy_cnt = 0;
    for (int s = 0; s < 2*L; s++) begin
      if (s == 1) valid_i = 1'b0;
      if (chg && s == 3) begin fmt_i = nf; wsel_i = nw; end
      do_slot(is_dsp(mf) ? (s == 0) : (s >= L), got);
      raw = model_raw(mf, w, L, s, v ? l : 32'h0, v ? r : 32'h0);
      exp = (mf == 0 || mf == 3) ? prev_raw : raw;
      prev_raw = raw;
      if (got !== exp && miss == 0) begin mslot = s; mg = got; me = exp; end
      if (got !== exp) miss++;
    end
    if (chk) begin
      tag = {fmt_tag(mf), " R8"};
      if (bclk_inv_i) tag = {tag, " R6"};
      if (frame_inv_i) tag = {tag, " R7"};
      tag = {tag, xtag};
      check(miss == 0, tag, $sformatf("fmt=%0d w=%0d L=%0d slot=%0d", mf, w, L, mslot),
            {31'h0, mg}, {31'h0, me});
      check(rdy_cnt == 1, "R9", "ready pulses per frame", rdy_cnt, 1);
    end
  endtask

  task automatic scen(input logic [2:0] f, input logic [1:0] ws, input bit bi,
                      input bit fi, input int len, input int nchk);
    fmt_i = f; wsel_i = ws; bclk_inv_i = bi; frame_inv_i = fi; L = len;
    for (int k = 0; k < 2; k++) run_frame(0, 1, $urandom, $urandom, 0, 0, 0, "");
    for (int k = 0; k < nchk; k++) run_frame(1, 1, $urandom, $urandom, 0, 0, 0, "");
  endtask

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk_i);
    // R12 reset state
    check(sdata_o == 1'b0, "R12", "sdata after reset", {31'h0, sdata_o}, 0);
    check(underrun_o == 1'b0, "R12", "underrun after reset", {31'h0, underrun_o}, 0);
    check(ready_o == 1'b0, "R12", "ready after reset", {31'h0, ready_o}, 0);
    rst_ni = 1'b1;
    wait_neg(2);

    // tight W==L and narrow width, every format
    for (int f = 0; f < 5; f++) scen(3'(f), 2'd3, 0, 0, 32, 2);
    for (int f = 0; f < 5; f++) scen(3'(f), 2'd0, 0, 0, 32, 1);
    // inversions
    scen(3'd0, 2'd2, 1, 0, 32, 2);
    scen(3'd4, 2'd1, 0, 1, 36, 2);
    scen(3'd2, 2'd0, 1, 1, 36, 2);
    scen(3'd3, 2'd3, 1, 1, 32, 1);

    // R11: width change mid-frame holds until the next frame start
    scen(3'd1, 2'd0, 0, 0, 32, 1);
    run_frame(1, 1, $urandom, $urandom, 1, 3'd1, 2'd2, " R11");
    run_frame(1, 1, $urandom, $urandom, 0, 0, 0, " R11");
    // R11: format change mid-frame within the same family
    run_frame(1, 1, $urandom, $urandom, 1, 3'd2, 2'd3, " R11");
    run_frame(1, 1, $urandom, $urandom, 0, 0, 0, " R11");

    // R10: underrun
    scen(3'd0, 2'd1, 0, 0, 32, 1);
    run_frame(1, 0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 0, 0, 0, " R10");
    check(underrun_o == 1'b1, "R10", "underrun set", {31'h0, underrun_o}, 1);
    run_frame(1, 1, $urandom, $urandom, 0, 0, 0, " R10");
    check(underrun_o == 1'b1, "R10", "underrun sticky", {31'h0, underrun_o}, 1);
    underrun_clr_i = 1'b1;
    wait_neg(1);
    underrun_clr_i = 1'b0;
    wait_neg(1);
    check(underrun_o == 1'b0, "R10", "underrun cleared", {31'h0, underrun_o}, 0);

    // constrained random
    for (int k = 0; k < 12; k++)
      scen(3'($urandom_range(0, 4)), 2'($urandom_range(0, 3)), 1'($urandom_range(0, 1)),
           1'($urandom_range(0, 1)), ($urandom_range(0, 1) != 0) ? 36 : 32, 2);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk_i);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog act=%0d exp=%0d", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule